// File: doc/BRIEF.md
# Narrow-Host Quadlet Assembly Register

This block lets a host with an 8-bit or 16-bit data bus make single 32-bit writes into a block of internal registers. The host fills a 32-bit staging register one byte or one halfword at a time, in any order, by writing with the top address line low. It then writes the last lane to the address of the intended internal register with the top address line high. That write merges the lane or lanes on the bus with the staged bytes and sends one 32-bit write out of the internal write port.

Reads with the top address line low return the staging register on the addressed lane. The staging register powers up holding a fixed pattern with four distinct bytes, so after reset the host can read it back and check how its bus lanes and bit polarity map into the device. A commit leaves the staging register unchanged, so a word that differs in one lane from the previous one needs only a single bus write.

Top module: `quad_stager`

## Requirements
- R1: After reset the staging register holds 0x0F0A0500 and `reg_we` is low.
- R2: In byte mode (`half_mode`=0), a write with `host_addr[8]`=0 puts `host_wdata[7:0]` into byte `host_addr[1:0]` of the staging register (byte 0 = bits 7:0) and leaves the other three bytes unchanged. Bytes may be written in any order.
- R3: In halfword mode (`half_mode`=1), `host_addr[1]` selects the halfword (0 = bits 15:0, 1 = bits 31:16). `host_be[0]` enables the low byte and `host_be[1]` enables the high byte of that halfword. `host_addr[0]` has no effect.
- R4: While `host_re`=1 and `host_addr[8]`=0, `host_rdata` shows the staged contents in the same cycle. In byte mode it shows the addressed byte on bits 7:0 with bits 15:8 zero. In halfword mode it shows the addressed halfword. In every other case `host_rdata` is zero.
- R5: A write with `host_addr[8]`=1 raises `reg_we` on the next clock edge. `reg_wdata` then holds the lanes written in that cycle (selected as in R2/R3) and the staging register's contents in all other lanes.
- R6: For a commit, `reg_addr` equals `host_addr[7:0]` with bits 1:0 cleared, so all four byte addresses of a quadlet reach the same target.
- R7: A commit leaves the staging register unchanged.
- R8: In byte mode `host_be` has no effect.
- R9: `reg_we` is high for exactly one cycle per commit and is low in every cycle that does not follow a commit write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_mode | input | 1 | 0: 8-bit host, 1: 16-bit host |
| host_addr | input | 9 | Host address; bit 8 selects a commit (1) or a staging access (0) |
| host_wdata | input | 16 | Host write data |
| host_be | input | 2 | Byte enables within a halfword (halfword mode only) |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data |
| reg_we | output | 1 | Internal 32-bit write strobe |
| reg_addr | output | 8 | Internal target address, quadlet aligned |
| reg_wdata | output | 32 | Internal 32-bit write data |

## Verification
The hardest case is a commit whose outgoing word mixes lanes from two sources. The lanes written in the commit cycle come from the bus, and the other lanes come from a staging register that earlier writes, in a scattered order, have left partly updated. To reach it, the bench stages lanes out of order in both bus widths. It uses partial byte enables and addresses with stray low bits, and then commits through each of the four byte addresses of a quadlet. A behavioural model of the staging contents predicts every output on every clock. Reads taken after each commit show that the staged bytes survived.

// File: rtl/quad_stager.sv
module quad_stager #(
  parameter int          ADDR_W    = 9,
  parameter logic [31:0] RESET_VAL = 32'h0F0A0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_mode,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  input  logic [1:0]        host_be,
  input  logic              host_we,
  input  logic              host_re,
  output logic [15:0]       host_rdata,
  output logic              reg_we,
  output logic [ADDR_W-2:0] reg_addr,
  output logic [31:0]       reg_wdata
);
  localparam int SEL = ADDR_W - 1;

  logic [31:0] stage_q;
  logic [3:0]  lane_en;
  logic [31:0] lane_data;
  logic [31:0] merged;
  wire         commit = host_we & host_addr[SEL];
  wire         stage_wr = host_we & ~host_addr[SEL];

  always_comb begin
    if (half_mode) begin
      lane_en   = host_addr[1] ? {host_be, 2'b00} : {2'b00, host_be};
      lane_data = {2{host_wdata}};
    end else begin
      lane_en   = 4'b0001 << host_addr[1:0];
      lane_data = {4{host_wdata[7:0]}};
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged[8*g +: 8] = lane_en[g] ? lane_data[8*g +: 8] : stage_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= RESET_VAL;
    else if (stage_wr) stage_q <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= commit;
      if (commit) begin
        reg_addr  <= {host_addr[SEL-1:2], 2'b00};
        reg_wdata <= merged;
      end
    end
  end

  assign host_rdata = (!host_re || host_addr[SEL]) ? 16'h0 :
                      half_mode ? (host_addr[1] ? stage_q[31:16] : stage_q[15:0]) :
                      {8'h00, stage_q[8*host_addr[1:0] +: 8]};

  AST_COMMIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr[SEL]) |=> reg_we); // R5
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr[SEL]) |=> !reg_we); // R9
  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_addr[1:0] == 2'b00); // R6
  AST_COMMIT_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr[SEL]) |=> $stable(stage_q)); // R7
  AST_IDLE_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> $stable(stage_q)); // R2
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_re || host_addr[SEL]) |-> host_rdata == 16'h0); // R4
endmodule

// File: tb/test_quad_stager.sv
module test_quad_stager;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_mode = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [15:0] host_rdata;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_stage = 32'h0F0A0500;
  logic        m_we = 1'b0;
  logic [7:0]  m_addr = '0;
  logic [31:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_stager i_quad_stager (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_we(host_we), .host_re(host_re),
    .host_rdata(host_rdata), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  always @(posedge clk) begin
    logic [31:0] nxt;
    nxt = m_stage;
    for (int b = 0; b < 4; b++) begin
      bit hit;
      if (half_mode) hit = (int'(host_addr[1]) == b / 2) && host_be[b % 2];
      else           hit = int'(host_addr[1:0]) == b;
      if (hit) nxt[8*b +: 8] = half_mode ? host_wdata[8*(b % 2) +: 8] : host_wdata[7:0];
    end
    if (!rst_n) begin
      m_stage = 32'h0F0A0500;
      m_we = 1'b0;
      m_addr = '0;
      m_data = '0;
    end else begin
      m_we = host_we && host_addr[8];
      if (host_we && host_addr[8]) begin
        m_addr = host_addr[7:0] & 8'hFC;
        m_data = nxt;
      end else if (host_we) begin
        m_stage = nxt;
      end
    end
  end

  function automatic logic [15:0] exp_read();
    if (!host_re || host_addr[8]) return 16'h0;
    if (half_mode) return host_addr[1] ? m_stage[31:16] : m_stage[15:0];
    return {8'h00, m_stage[8*host_addr[1:0] +: 8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic hm, input logic we, input logic re,
                      input logic [8:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    check(m_we ? "R5 reg_we" : "R9 reg_we", {31'b0, reg_we}, {31'b0, m_we});
    if (m_we) begin
      check("R6 reg_addr", {24'b0, reg_addr}, {24'b0, m_addr});
      check("R5 reg_wdata", reg_wdata, m_data);
    end
    half_mode = hm; host_we = we; host_re = re; host_addr = a; host_wdata = d; host_be = be;
    #1;
    check(tag, {16'b0, host_rdata}, {16'b0, exp_read()});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset image read back bytewise and halfwise
    for (int i = 0; i < 4; i++) step("R1 reset byte", 0, 0, 1, 9'(i), 16'h0, 2'b00);
    step("R1 reset half lo", 1, 0, 1, 9'h000, 16'h0, 2'b00);
    step("R1 reset half hi", 1, 0, 1, 9'h002, 16'h0, 2'b00);
    check("R1 reg_we", {31'b0, reg_we}, 32'h0);
    // R2 out-of-order byte staging, then commit on a middle byte address
    step("R2 stage b2", 0, 1, 0, 9'h002, 16'hEE33, 2'b00);
    step("R2 stage b0", 0, 1, 0, 9'h000, 16'hDD11, 2'b00);
    step("R2 stage b3", 0, 1, 0, 9'h003, 16'hCC44, 2'b00);
    step("R5 commit b1", 0, 1, 0, 9'h189, 16'h0022, 2'b00);
    for (int i = 0; i < 4; i++) step("R7 stage kept", 0, 0, 1, 9'(i), 16'h0, 2'b00);
    // R4 reads with select high return zero
    step("R4 read sel high", 0, 0, 1, 9'h101, 16'h0, 2'b00);
    step("R4 read half sel high", 1, 0, 1, 9'h102, 16'h0, 2'b00);
    // R3 halfword staging, partial enables, stray bit 0
    step("R3 stage hi", 1, 1, 0, 9'h003, 16'hBEEF, 2'b11);
    step("R3 stage lo byte", 1, 1, 0, 9'h001, 16'h5A77, 2'b01);
    step("R3 read lo", 1, 0, 1, 9'h000, 16'h0, 2'b00);
    step("R3 read hi odd", 1, 0, 1, 9'h003, 16'h0, 2'b00);
    step("R3 stage lo hi byte", 1, 1, 0, 9'h000, 16'h6600, 2'b10);
    step("R3 read lo", 1, 0, 1, 9'h001, 16'h0, 2'b00);
    step("R5 half commit hi", 1, 1, 0, 9'h1F6, 16'h1234, 2'b11);
    step("R5 half commit partial", 1, 1, 0, 9'h1F1, 16'hABCD, 2'b10);
    step("R3 after commit", 1, 0, 1, 9'h002, 16'h0, 2'b00);
    // R8 byte enables ignored in byte mode
    step("R8 be zero write", 0, 1, 0, 9'h001, 16'hFF99, 2'b00);
    step("R8 read", 0, 0, 1, 9'h001, 16'h0, 2'b00);
    step("R8 be mixed write", 0, 1, 0, 9'h003, 16'h0081, 2'b10);
    step("R8 read", 0, 0, 1, 9'h003, 16'h0, 2'b00);
    // R6 commits through each byte address, back to back
    for (int i = 0; i < 4; i++) step("R6 commit", 0, 1, 0, 9'h140 + 9'(i), 16'(8'h10 + i), 2'b11);
    step("R9 idle", 0, 0, 0, 9'h000, 16'h0, 2'b00);
    step("R9 idle read", 0, 0, 1, 9'h002, 16'h0, 2'b00);
    step("R9 idle", 0, 0, 0, 9'h000, 16'h0, 2'b00);
    // reset restores the image
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reg_we after reset", {31'b0, reg_we}, 32'h0);
    for (int i = 0; i < 4; i++) step("R1 reset again", 0, 0, 1, 9'(i), 16'h0, 2'b00);
    step("R9 final", 0, 0, 0, 9'h000, 16'h0, 2'b00);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule